// File: doc/BRIEF.md
# Configurable External Interrupt Edge Detector

This block watches one external interrupt pin and raises a sticky request flag when the waveform chosen by software appears on it. A 4-bit control register selects four things. It enables the pin input. It chooses the active polarity. It picks detection of one edge or of both edges. It lets the pin gate an associated timer. Software writes the register and reads it back over a plain register port. A CPU acknowledge pulse clears the flag.

The pin is synchronised first. It is then folded with the polarity and enable bits into one effective input, and an edge is found by comparing the current and previous values of that input. Because the register feeds this effective input, a configuration write that changes it counts as an edge and can raise the request. A level-test output reports whether the pin sits at the selected level, for use by a conditional-skip instruction. A timer gate output follows the pin when the timer control bit is set. The block is normally instantiated twice, one instance per pin. The second instance is built without the timer gate.

Top module: `extint_edge_detect`

## Requirements
- R1: After reset the control register reads 0000, and the request flag, level test and timer gate outputs are all 0.
- R2: A write (regWrEn high for one cycle) loads all four bits so that regRdData shows them after that clock edge. Without a write the register holds its value however long the pin keeps toggling.
- R3: With bit 3 (input enable) at 0, pin activity and configuration writes never set the request flag, and levelTest and timerGate stay 0.
- R4: With bit 3 set, levelTest is 1 when the synchronised pin equals bit 2. Bit 2 = 1 selects the high level and bit 2 = 0 selects the low level. levelTest follows a pin change after two clock edges.
- R5: With bit 1 = 0 (single-edge mode), only the edge chosen by bit 2 sets the flag: rising when bit 2 = 1, falling when bit 2 = 0. The flag reads 1 after the third rising clock edge following the pin change, and is still 0 after the second.
- R6: With bit 1 = 1 (both-edge mode), rising and falling pin edges both set the flag.
- R7: A configuration write that changes the enable or polarity bit so that the effective input goes from inactive to active sets the flag one clock edge after the write takes effect.
- R8: The flag stays set until a one-cycle ackIn pulse clears it. If a new edge lands in the same cycle as the acknowledge, the flag stays set.
- R9: timerGate is 1 only when bit 0, bit 3 and the selected pin level (levelTest) are all true.
- R10: When built with HAS_TIMER_GATE = 0, bit 0 still reads back what was written but timerGate is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | 1 | Raw external interrupt pin |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 4 | Value to write: bit 3 enable, bit 2 polarity, bit 1 both-edge, bit 0 timer control |
| regRdData | output | 4 | Current control register contents |
| ackIn | input | 1 | One-cycle acknowledge that clears the request flag |
| reqFlag | output | 1 | Sticky interrupt request flag |
| levelTest | output | 1 | Pin is at the selected level and input is enabled |
| timerGate | output | 1 | Gate for the associated timer |

## Verification
A corrupted control register shows at regRdData on the very next cycle, since the readback is the register itself. A broken synchroniser or edge memory shows as a flag that rises one cycle early or late against the fixed three-edge latency, or that rises on the wrong edge within three cycles of the pin change. A wrong flag state persists until the next acknowledge, so the checks read reqFlag both before and after each ack pulse, and also with an edge arriving together with the ack, where a flag that fails to hold is caught one cycle after the pulse.

// File: rtl/extint_pkg.sv
package extint_pkg;

  localparam int CFG_W = 4;

  // Field order matches the register bit order, MSB first.
  typedef struct packed {
    logic inEn;       // bit 3
    logic polHigh;    // bit 2
    logic bothEdges;  // bit 1
    logic timerEn;    // bit 0
  } ctrlReg_t;

  typedef struct packed {
    logic inEn;
    logic polHigh;
    logic bothEdges;
    logic timerEn;
    logic ackClr;
  } dpStrobe_t;

endpackage

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter bit HAS_TIMER_GATE = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [CFG_W-1:0] regWrData,
  input  logic             ackIn,
  output logic [CFG_W-1:0] regRdData,
  output dpStrobe_t        strobes
);

  ctrlReg_t cfgQ;

  // Contents persist through any low-power hold; only reset clears them.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (regWrEn) begin
      cfgQ <= ctrlReg_t'(regWrData);
    end
  end

  assign regRdData         = cfgQ;
  assign strobes.inEn      = cfgQ.inEn;
  assign strobes.polHigh   = cfgQ.polHigh;
  assign strobes.bothEdges = cfgQ.bothEdges;
  assign strobes.ackClr    = ackIn;

  generate
    if (HAS_TIMER_GATE) begin : g_timer
      assign strobes.timerEn = cfgQ.timerEn;
    end else begin : g_noTimer
      // Bit is storage only in this variant.
      assign strobes.timerEn = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/extint_datapath.sv
module extint_datapath
  import extint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      pinIn,
  input  dpStrobe_t strobes,
  output logic      reqFlag,
  output logic      levelTest,
  output logic      timerGate,
  output logic      edgeDet
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic syncPin;
  logic effIn;
  logic effPrev;
  logic riseEv;
  logic fallEv;
  logic flagQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
    end
  end

  assign syncPin = syncQ[SYNC_STAGES-1];

  // Active-high view of the pin: inverted for low polarity, forced low when disabled.
  assign effIn = (syncPin ^ ~strobes.polHigh) & strobes.inEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      effPrev <= 1'b0;
    end else begin
      effPrev <= effIn;
    end
  end

  assign riseEv  = effIn & ~effPrev;
  assign fallEv  = ~effIn & effPrev;
  assign edgeDet = riseEv | (strobes.bothEdges & fallEv);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (edgeDet) begin
      flagQ <= 1'b1;
    end else if (strobes.ackClr) begin
      flagQ <= 1'b0;
    end
  end

  assign reqFlag   = flagQ;
  assign levelTest = effIn;
  assign timerGate = strobes.timerEn & effIn;

endmodule

// File: rtl/extint_edge_detect.sv
module extint_edge_detect
  import extint_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter bit HAS_TIMER_GATE = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinIn,
  input  logic             regWrEn,
  input  logic [CFG_W-1:0] regWrData,
  output logic [CFG_W-1:0] regRdData,
  input  logic             ackIn,
  output logic             reqFlag,
  output logic             levelTest,
  output logic             timerGate
);

  dpStrobe_t strobes;
  logic edgeDet;

  extint_ctrl #(
    .HAS_TIMER_GATE(HAS_TIMER_GATE)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .ackIn    (ackIn),
    .regRdData(regRdData),
    .strobes  (strobes)
  );

  extint_datapath #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .pinIn    (pinIn),
    .strobes  (strobes),
    .reqFlag  (reqFlag),
    .levelTest(levelTest),
    .timerGate(timerGate),
    .edgeDet  (edgeDet)
  );

endmodule

// File: rtl/extint_edge_detect_chk.sv
module extint_edge_detect_chk (
  input logic       clk,
  input logic       rstN,
  input logic       regWrEn,
  input logic [3:0] regWrData,
  input logic [3:0] regRdData,
  input logic       ackIn,
  input logic       reqFlag,
  input logic       levelTest,
  input logic       timerGate,
  input logic       edgeDet
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (regRdData == 4'b0000 && !reqFlag));

  // R2
  reg_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> regRdData == $past(regWrData));

  // R2
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> $stable(regRdData));

  // R3
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regRdData[3] |-> (!levelTest && !timerGate));

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && !edgeDet) |=> !reqFlag);

  // R8
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    edgeDet |=> reqFlag);

  // R5
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqFlag) |-> $past(edgeDet));

  // R9
  gate_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    timerGate |-> (levelTest && regRdData[0]));

endmodule

bind extint_edge_detect extint_edge_detect_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWrEn  (regWrEn),
  .regWrData(regWrData),
  .regRdData(regRdData),
  .ackIn    (ackIn),
  .reqFlag  (reqFlag),
  .levelTest(levelTest),
  .timerGate(timerGate),
  .edgeDet  (edgeDet)
);

// File: tb/extint_edge_detect_bench.sv
module extint_edge_detect_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pinIn = 1'b0;
  logic ackIn = 1'b0;
  logic regWrEn = 1'b0;
  logic [3:0] regWrData = 4'b0;
  logic regWrEn2 = 1'b0;
  logic [3:0] regWrData2 = 4'b0;
  logic [3:0] regRdData, regRdData2;
  logic reqFlag, levelTest, timerGate;
  logic reqFlag2, levelTest2, timerGate2;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  extint_edge_detect u_extint_edge_detect (
    .clk(clk), .rstN(rstN), .pinIn(pinIn),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .ackIn(ackIn), .reqFlag(reqFlag), .levelTest(levelTest), .timerGate(timerGate)
  );

  extint_edge_detect #(.HAS_TIMER_GATE(1'b0)) u_extint_edge_detect_nogate (
    .clk(clk), .rstN(rstN), .pinIn(pinIn),
    .regWrEn(regWrEn2), .regWrData(regWrData2), .regRdData(regRdData2),
    .ackIn(ackIn), .reqFlag(reqFlag2), .levelTest(levelTest2), .timerGate(timerGate2)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wrReg(input logic [3:0] v);
    regWrData = v;
    regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic wrReg2(input logic [3:0] v);
    regWrData2 = v;
    regWrEn2 = 1'b1;
    tick();
    regWrEn2 = 1'b0;
  endtask

  task automatic pulseAck();
    ackIn = 1'b1;
    tick();
    ackIn = 1'b0;
  endtask

  task automatic cleanup();
    wrReg(4'b0000);
    tick();
    pulseAck();
  endtask

  task automatic testReset();
    check("R1", "regRdData", regRdData, 0);
    check("R1", "reqFlag", reqFlag, 0);
    check("R1", "levelTest", levelTest, 0);
    check("R1", "timerGate", timerGate, 0);
  endtask

  task automatic testReadback();
    wrReg(4'b0110);
    check("R2", "readback 0110", regRdData, 6);
    wrReg(4'b0001);
    check("R2", "readback 0001", regRdData, 1);
    for (int i = 0; i < 6; i++) begin
      pinIn = ~pinIn;
      tick(2);
    end
    check("R2", "held while pin toggles", regRdData, 1);
    pinIn = 1'b0;
    tick(3);
    cleanup();
  endtask

  task automatic testDisabled();
    wrReg(4'b0111);
    for (int i = 0; i < 4; i++) begin
      pinIn = ~pinIn;
      tick(3);
    end
    check("R3", "flag with input disabled", reqFlag, 0);
    pinIn = 1'b1;
    tick(3);
    check("R3", "levelTest disabled", levelTest, 0);
    check("R3", "timerGate disabled", timerGate, 0);
    pinIn = 1'b0;
    tick(3);
    cleanup();
  endtask

  task automatic testRiseSingle();
    wrReg(4'b1100);
    tick();
    check("R5", "no flag at config", reqFlag, 0);
    pinIn = 1'b1;
    tick(2);
    check("R5", "flag after two edges", reqFlag, 0);
    check("R4", "high level seen", levelTest, 1);
    tick();
    check("R5", "flag after third edge", reqFlag, 1);
    pulseAck();
    check("R8", "ack clears", reqFlag, 0);
    pinIn = 1'b0;
    tick(4);
    check("R5", "falling ignored in rising mode", reqFlag, 0);
    check("R4", "low level not selected", levelTest, 0);
    cleanup();
  endtask

  task automatic testFallSingle();
    pinIn = 1'b1;
    tick(3);
    wrReg(4'b1000);
    tick();
    check("R5", "no flag high pin low pol", reqFlag, 0);
    check("R4", "high pin with low pol", levelTest, 0);
    pinIn = 1'b0;
    tick(2);
    check("R4", "low level seen", levelTest, 1);
    tick();
    check("R5", "falling edge sets flag", reqFlag, 1);
    pulseAck();
    pinIn = 1'b1;
    tick(4);
    check("R5", "rising ignored in falling mode", reqFlag, 0);
    pinIn = 1'b0;
    tick(3);
    cleanup();
  endtask

  task automatic testBoth();
    wrReg(4'b1110);
    tick();
    check("R6", "no flag at config", reqFlag, 0);
    pinIn = 1'b1;
    tick(3);
    check("R6", "rising sets flag", reqFlag, 1);
    pulseAck();
    check("R6", "cleared", reqFlag, 0);
    pinIn = 1'b0;
    tick(3);
    check("R6", "falling sets flag", reqFlag, 1);
    // flag still set; next edge collides with ack
    pinIn = 1'b1;
    tick(2);
    ackIn = 1'b1;
    tick();
    ackIn = 1'b0;
    check("R8", "edge wins over ack", reqFlag, 1);
    tick(3);
    check("R8", "sticky without ack", reqFlag, 1);
    pulseAck();
    check("R8", "ack alone clears", reqFlag, 0);
    pinIn = 1'b0;
    tick(3);
    cleanup();
  endtask

  task automatic testConfigEdge();
    pinIn = 1'b0;
    tick(3);
    wrReg(4'b1000);
    check("R7", "flag same cycle as write", reqFlag, 0);
    tick();
    check("R7", "write made effective edge", reqFlag, 1);
    pulseAck();
    pinIn = 1'b1;
    tick(3);
    pulseAck();
    wrReg(4'b1100);
    tick();
    check("R7", "polarity flip raises flag", reqFlag, 1);
    pinIn = 1'b0;
    tick(3);
    cleanup();
  endtask

  task automatic testTimerGate();
    pinIn = 1'b1;
    tick(3);
    wrReg(4'b1101);
    check("R9", "gate open", timerGate, 1);
    wrReg(4'b1100);
    check("R9", "gate off with bit0 clear", timerGate, 0);
    wrReg(4'b1101);
    pinIn = 1'b0;
    tick(2);
    check("R9", "gate off at inactive level", timerGate, 0);
    pinIn = 1'b1;
    tick(2);
    wrReg2(4'b1101);
    check("R10", "bit0 readback", regRdData2, 13);
    check("R10", "level on variant", levelTest2, 1);
    check("R10", "no gate on variant", timerGate2, 0);
    pinIn = 1'b0;
    tick(3);
    wrReg2(4'b0000);
    cleanup();
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick();
    testReset();
    testReadback();
    testDisabled();
    testRiseSingle();
    testFallSingle();
    testBoth();
    testConfigEdge();
    testTimerGate();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule